// File: doc/BRIEF.md
# IDE Host Transfer Signal Sequencer

This block is the host side of one parallel ATA channel. It drives the active-low read and write command strobes and the active-low DMA acknowledge, samples the device's DMA request, and moves 16-bit words for three kinds of transfer: programmed register cycles (PIO), multiword DMA cycles and Ultra DMA bursts. A requester starts a transfer with a mode, a direction and a word count. Write words arrive on a valid/ready stream. Read words leave as one-cycle valid pulses, gated by a sink-ready input.

In PIO and multiword DMA, a strobe low phase and a recovery phase are timed from configuration inputs. In Ultra DMA the two strobe pins take other roles. On reads, the read-strobe pin becomes the host's ready line. On writes, it becomes a data strobe that toggles once per word. During any burst, the write-strobe pin becomes the stop line. A power-off suspend input parks the channel and releases the write-strobe pin.

Top module: `ide_xfer_seq`

## Requirements
- R1: During reset and afterwards, `ide_dior_n`, `ide_diow_n` and `ide_dmack_n` are high, `ide_diow_oe` is 1, `ide_dd_oe` is 0, `done` and `err` are 0, and `req_ready` is 1.
- R2: `req_mode` selects the transfer type: 2 is Ultra DMA, 1 is multiword DMA, and any other value is PIO. In PIO and multiword DMA, the selected strobe (`ide_dior_n` for reads, `ide_diow_n` for writes) is low for exactly `cfg_active` cycles per word, then high for `cfg_recover` cycles plus at least one. A value of 0 in either field counts as 1.
- R3: On a PIO or multiword DMA read, `rd_valid` pulses for one cycle right after the read strobe rises. `rd_data` then holds the bus value from the last low cycle. A read word starts only while `rd_ready` is 1.
- R4: On a PIO or multiword DMA write, a word is taken when `wr_valid` and `wr_ready` are both 1. `ide_dd_out` carries that word, with `ide_dd_oe` at 1, from the falling edge of the write strobe until past its rising edge.
- R5: In multiword DMA, `ide_dmack_n` falls only after `ide_dmarq` has been sampled high. Each word starts only while `ide_dmarq` is 1. `ide_dmack_n` rises with `done`.
- R6: In an Ultra DMA read, `ide_dior_n` is the inverse of `rd_ready`, registered. Each change of `ide_dstrobe` captures one word into `rd_data` with a `rd_valid` pulse, until the count is used up.
- R7: In an Ultra DMA write, each word taken loads `ide_dd_out`, and `ide_dior_n` toggles one cycle later. At most one word is taken every two cycles.
- R8: An Ultra DMA burst ends when the count is used up or `ide_dmarq` is low. `ide_diow_n` is then low for `STOP_HOLD` cycles. After that, `ide_diow_n`, `ide_dior_n` and `ide_dmack_n` rise together with a one-cycle `done`.
- R9: `err` is 1 only together with `done`, and only when an Ultra DMA burst ended before all requested words moved.
- R10: A request with a count of 0 gives `done`, with `err` at 0, in the following cycle and drives no strobe.
- R11: While `suspend` is 1, from the next cycle `ide_dior_n` and `ide_dmack_n` are high, `ide_diow_oe` and `ide_dd_oe` are 0, `req_ready` is 0, and any transfer is abandoned without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend | input | 1 | Power-off suspend: park and release the write strobe |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_mode | input | 2 | 2 Ultra DMA, 1 multiword DMA, else PIO |
| req_write | input | 1 | 1 host to device, 0 device to host |
| req_count | input | CNT_W | Number of words |
| cfg_active | input | TIME_W | Strobe low clocks (PIO/multiword DMA) |
| cfg_recover | input | TIME_W | Recovery clocks (PIO/multiword DMA) |
| wr_data | input | DW | Write word |
| wr_valid | input | 1 | Write word available |
| wr_ready | output | 1 | Block takes the write word this cycle |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | One-cycle pulse per read word |
| rd_ready | input | 1 | Read sink can accept words |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Burst stopped early (with done) |
| ide_dior_n | output | 1 | Read strobe / host ready / write data strobe |
| ide_diow_n | output | 1 | Write strobe / burst stop |
| ide_diow_oe | output | 1 | Drive enable of the write strobe pin |
| ide_dmack_n | output | 1 | DMA acknowledge |
| ide_dmarq | input | 1 | Device DMA request |
| ide_dstrobe | input | 1 | Device data strobe for Ultra DMA reads |
| ide_dd_in | input | DW | Data bus input |
| ide_dd_out | output | DW | Data bus output |
| ide_dd_oe | output | 1 | Data bus drive enable |

## Verification
A wrong phase timer count shows on the strobe pins in the same word. The low or recovery phase is one cycle off at the very next strobe edge. A word counter that slips shows as an extra or missing strobe toggle, or an early stop, before `done`. A corrupted mode or direction latch drives the wrong pin on the first word, within a few cycles of the request. The bench runs a reference of the pin behaviour beside the design and compares every output on every cycle, so any of these faults appears in the cycle where the pins first differ.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;
  typedef enum logic [1:0] {
    XF_PIO  = 2'd0,
    XF_MDMA = 2'd1,
    XF_UDMA = 2'd2
  } xfer_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_ACT, S_REC, S_UWAIT, S_URUN, S_USTOP
  } seq_state_e;
endpackage

// File: rtl/ide_phase_timer.sv
module ide_phase_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         last
);
  logic [W-1:0] cnt;

  // a zero load counts as one clock
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= (val == '0) ? W'(1) : val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/ide_word_ctr.sv
module ide_word_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)                      left <= '0;
    else if (load)                left <= init;
    else if (dec && left != '0)   left <= left - W'(1);
  end

  assign zero = (left == '0);
endmodule

// File: rtl/ide_xfer_seq.sv
module ide_xfer_seq import ide_seq_pkg::*; #(
  parameter int CNT_W     = 16,
  parameter int TIME_W    = 6,
  parameter int DW        = 16,
  parameter int STOP_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              suspend,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_mode,
  input  logic              req_write,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [TIME_W-1:0] cfg_active,
  input  logic [TIME_W-1:0] cfg_recover,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              done,
  output logic              err,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  output logic              ide_diow_oe,
  output logic              ide_dmack_n,
  input  logic              ide_dmarq,
  input  logic              ide_dstrobe,
  input  logic [DW-1:0]     ide_dd_in,
  output logic [DW-1:0]     ide_dd_out,
  output logic              ide_dd_oe
);
  localparam logic [TIME_W-1:0] HOLD_T = TIME_W'(STOP_HOLD);

  seq_state_e        st;
  xfer_mode_e        mode_r;
  logic              wr_r, pend, dstb_prev;
  logic              t_load, t_last;
  logic [TIME_W-1:0] t_val;
  logic              c_dec, c_zero;
  logic              acc, dev_ok, go_pio, take_u, stb_tog, u_end, act_end;

  assign req_ready = (st == S_IDLE) && !suspend;
  assign acc       = req_valid && req_ready;
  assign dev_ok    = (mode_r != XF_MDMA) || ide_dmarq;
  assign go_pio    = (st == S_WAIT) && dev_ok && (wr_r ? wr_valid : rd_ready);
  assign wr_ready  = !suspend && wr_r &&
                     (((st == S_WAIT) && dev_ok) ||
                      ((st == S_URUN) && ide_dmarq && !pend && !c_zero));
  assign take_u    = (st == S_URUN) && wr_valid && wr_ready;
  assign stb_tog   = (st == S_URUN) && !wr_r && (ide_dstrobe != dstb_prev) && !c_zero;
  assign u_end     = (st == S_URUN) &&
                     (wr_r ? (!pend && (c_zero || !ide_dmarq)) : (c_zero || !ide_dmarq));
  assign act_end   = (st == S_ACT) && t_last;

  assign t_load = go_pio || act_end || u_end;
  assign t_val  = go_pio ? cfg_active : (act_end ? cfg_recover : HOLD_T);
  assign c_dec  = act_end || take_u || stb_tog;

  ide_phase_timer #(.W(TIME_W)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .last(t_last)
  );

  ide_word_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(acc), .init(req_count), .dec(c_dec), .zero(c_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; mode_r <= XF_PIO; wr_r <= 1'b0; pend <= 1'b0; dstb_prev <= 1'b0;
      ide_dior_n <= 1'b1; ide_diow_n <= 1'b1; ide_dmack_n <= 1'b1; ide_diow_oe <= 1'b1;
      ide_dd_oe <= 1'b0; ide_dd_out <= '0; rd_data <= '0; rd_valid <= 1'b0;
      done <= 1'b0; err <= 1'b0;
    end else if (suspend) begin
      st <= S_IDLE; pend <= 1'b0;
      ide_dior_n <= 1'b1; ide_diow_n <= 1'b1; ide_dmack_n <= 1'b1; ide_diow_oe <= 1'b0;
      ide_dd_oe <= 1'b0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      ide_diow_oe <= 1'b1;
      rd_valid    <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      case (st)
        S_IDLE: if (acc) begin
          wr_r   <= req_write;
          mode_r <= (req_mode == 2'd2) ? XF_UDMA : ((req_mode == 2'd1) ? XF_MDMA : XF_PIO);
          if (req_count == '0) done <= 1'b1;
          else st <= (req_mode == 2'd2) ? S_UWAIT : S_WAIT;
        end
        S_WAIT: if (go_pio) begin
          if (wr_r) begin
            ide_diow_n <= 1'b0; ide_dd_out <= wr_data; ide_dd_oe <= 1'b1;
          end else begin
            ide_dior_n <= 1'b0;
          end
          if (mode_r == XF_MDMA) ide_dmack_n <= 1'b0;
          st <= S_ACT;
        end
        S_ACT: if (t_last) begin
          ide_dior_n <= 1'b1; ide_diow_n <= 1'b1;
          if (!wr_r) begin
            rd_data <= ide_dd_in; rd_valid <= 1'b1;
          end
          st <= S_REC;
        end
        S_REC: if (t_last) begin
          if (c_zero) begin
            done <= 1'b1; ide_dmack_n <= 1'b1; ide_dd_oe <= 1'b0; st <= S_IDLE;
          end else begin
            st <= S_WAIT;
          end
        end
        S_UWAIT: if (ide_dmarq) begin
          ide_dmack_n <= 1'b0; dstb_prev <= ide_dstrobe; pend <= 1'b0;
          ide_dd_oe <= wr_r; st <= S_URUN;
        end
        S_URUN: begin
          if (wr_r) begin
            if (pend) begin
              ide_dior_n <= !ide_dior_n; pend <= 1'b0;
            end else if (take_u) begin
              ide_dd_out <= wr_data; pend <= 1'b1;
            end
          end else begin
            ide_dior_n <= !rd_ready;
            dstb_prev  <= ide_dstrobe;
            if (stb_tog) begin
              rd_data <= ide_dd_in; rd_valid <= 1'b1;
            end
          end
          if (u_end) begin
            ide_diow_n <= 1'b0; st <= S_USTOP;
          end
        end
        S_USTOP: if (t_last) begin
          ide_diow_n <= 1'b1; ide_dior_n <= 1'b1; ide_dmack_n <= 1'b1; ide_dd_oe <= 1'b0;
          done <= 1'b1; err <= !c_zero; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ide_xfer_seq_chk.sv
module ide_xfer_seq_chk (
  input logic clk,
  input logic rst,
  input logic suspend,
  input logic ide_dior_n,
  input logic ide_diow_n,
  input logic ide_diow_oe,
  input logic ide_dmack_n,
  input logic ide_dmarq,
  input logic ide_dd_oe,
  input logic done,
  input logic err
);
  // R1: reset parks every strobe and the acknowledge high
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (ide_dior_n && ide_diow_n && ide_dmack_n && !done));

  // R11: suspend parks the pins and releases the write strobe
  a_r11_suspend_park: assert property (@(posedge clk) disable iff (rst)
    suspend |=> (ide_dior_n && ide_dmack_n && !ide_diow_oe && !ide_dd_oe));

  // R5: acknowledge only answers a sampled request
  a_r5_ack_after_req: assert property (@(posedge clk) disable iff (rst)
    $fell(ide_dmack_n) |-> $past(ide_dmarq));

  // R9: the error flag travels with done
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R2: outside DMA both command strobes are never low together
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    ide_dmack_n |-> (ide_dior_n || ide_diow_n));

  // R7: write data strobe never toggles on two edges in a row inside a burst
  a_r7_toggle_spacing: assert property (@(posedge clk) disable iff (rst)
    (!ide_dmack_n && !$past(ide_dmack_n) && ide_dd_oe && !$stable(ide_dior_n))
      |=> ($stable(ide_dior_n) || ide_dmack_n));
endmodule

bind ide_xfer_seq ide_xfer_seq_chk u_chk (
  .clk(clk), .rst(rst), .suspend(suspend),
  .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n), .ide_diow_oe(ide_diow_oe),
  .ide_dmack_n(ide_dmack_n), .ide_dmarq(ide_dmarq), .ide_dd_oe(ide_dd_oe),
  .done(done), .err(err)
);

// File: tb/sim_ide_xfer_seq.sv
`timescale 1ns/1ps
module sim_ide_xfer_seq;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1, suspend = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [15:0] req_count = '0;
  logic [5:0] cfg_active = 6'd1, cfg_recover = 6'd1;
  logic [15:0] wr_data = '0, ide_dd_in = '0;
  logic wr_valid = 1'b0, rd_ready = 1'b1, ide_dmarq = 1'b1, ide_dstrobe = 1'b0;
  logic req_ready, wr_ready, rd_valid, done, err;
  logic [15:0] rd_data, ide_dd_out;
  logic ide_dior_n, ide_diow_n, ide_diow_oe, ide_dmack_n, ide_dd_oe;

  always #2.5 clk = !clk;

  ide_xfer_seq #(.CNT_W(16), .TIME_W(6), .DW(16), .STOP_HOLD(HOLD)) u0 (
    .clk(clk), .rst(rst), .suspend(suspend),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_write(req_write), .req_count(req_count),
    .cfg_active(cfg_active), .cfg_recover(cfg_recover),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .err(err),
    .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n), .ide_diow_oe(ide_diow_oe),
    .ide_dmack_n(ide_dmack_n), .ide_dmarq(ide_dmarq), .ide_dstrobe(ide_dstrobe),
    .ide_dd_in(ide_dd_in), .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe)
  );

  int vectors = 0, miscompares = 0;

  task automatic cmp(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", tag, nm, act, exp);
    end
  endtask

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    vectors++;
    cmp(tag, nm, act, exp);
  endtask

  // ---------------- behavioural reference of the pins ----------------
  int ph = 0, tleft = 0, words = 0, mode = 0;
  bit dir = 0, pend = 0, prev = 0, armed = 0;
  bit m_dior = 1, m_diow = 1, m_dmack = 1, m_oe = 1, m_ddoe = 0;
  bit m_done = 0, m_err = 0, m_rdv = 0;
  logic [15:0] m_ddout = '0, m_rdd = '0;

  function automatic int at_least1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    bit stopc;
    armed = 1;
    m_done = 0; m_err = 0; m_rdv = 0;
    if (rst) begin
      ph = 0; pend = 0; m_dior = 1; m_diow = 1; m_dmack = 1; m_oe = 1; m_ddoe = 0;
    end else if (suspend) begin
      ph = 0; pend = 0; m_dior = 1; m_diow = 1; m_dmack = 1; m_oe = 0; m_ddoe = 0;
    end else begin
      m_oe = 1;
      case (ph)
        0: if (req_valid) begin
          mode = (req_mode == 2) ? 2 : ((req_mode == 1) ? 1 : 0);
          dir = req_write; words = req_count;
          if (req_count == 0) m_done = 1;
          else ph = (mode == 2) ? 4 : 1;
        end
        1: if ((mode != 1 || ide_dmarq) && (dir ? wr_valid : rd_ready)) begin
          if (dir) begin m_diow = 0; m_ddout = wr_data; m_ddoe = 1; end
          else m_dior = 0;
          if (mode == 1) m_dmack = 0;
          tleft = at_least1(cfg_active); ph = 2;
        end
        2: begin
          tleft--;
          if (tleft == 0) begin
            m_dior = 1; m_diow = 1;
            if (!dir) begin m_rdv = 1; m_rdd = ide_dd_in; end
            words--; tleft = at_least1(cfg_recover); ph = 3;
          end
        end
        3: begin
          tleft--;
          if (tleft == 0) begin
            if (words == 0) begin m_done = 1; m_dmack = 1; m_ddoe = 0; ph = 0; end
            else ph = 1;
          end
        end
        4: if (ide_dmarq) begin
          m_dmack = 0; prev = ide_dstrobe; pend = 0; m_ddoe = dir; ph = 5;
        end
        5: if (dir) begin
          if (pend) begin m_dior = !m_dior; pend = 0; end
          else if (words == 0 || !ide_dmarq) begin m_diow = 0; tleft = HOLD; ph = 6; end
          else if (wr_valid) begin m_ddout = wr_data; pend = 1; words--; end
        end else begin
          m_dior = !rd_ready;
          stopc = (words == 0) || !ide_dmarq;
          if (ide_dstrobe != prev && words != 0) begin
            m_rdv = 1; m_rdd = ide_dd_in; words--;
          end
          prev = ide_dstrobe;
          if (stopc) begin m_diow = 0; tleft = HOLD; ph = 6; end
        end
        6: begin
          tleft--;
          if (tleft == 0) begin
            m_diow = 1; m_dior = 1; m_dmack = 1; m_ddoe = 0;
            m_done = 1; m_err = (words != 0); ph = 0;
          end
        end
        default: ph = 0;
      endcase
    end
  end

  // ---------------- per-cycle compare and pattern driver ----------------
  logic [15:0] lfsr = 16'hACE1;
  bit wv_mode = 0, rr_mode = 0, dq_mode = 0, dq_level = 1;
  int stb_per = 0, stb_cnt = 0;
  bit seen_done = 0, seen_err = 0, last_dior = 1;
  int rdv_count = 0, tog_count = 0;

  always @(negedge clk) begin
    if (armed) begin
      vectors++;
      cmp("R2/R6/R7", "dior_n", ide_dior_n, m_dior);
      cmp("R8", "diow_n", ide_diow_n, m_diow);
      cmp("R5", "dmack_n", ide_dmack_n, m_dmack);
      cmp("R11", "diow_oe", ide_diow_oe, m_oe);
      cmp("R10", "done", done, m_done);
      cmp("R9", "err", err, m_err);
      cmp("R3/R6", "rd_valid", rd_valid, m_rdv);
      if (m_rdv) cmp("R3/R6", "rd_data", rd_data, m_rdd);
      cmp("R4", "dd_oe", ide_dd_oe, m_ddoe);
      if (m_ddoe) cmp("R4/R7", "dd_out", ide_dd_out, m_ddout);
      cmp("R1", "req_ready", req_ready, (ph == 0) && !suspend);
    end
    if (done) seen_done = 1;
    if (err) seen_err = 1;
    if (rd_valid) rdv_count++;
    if (!ide_dmack_n && ide_dd_oe && ide_dior_n != last_dior) tog_count++;
    last_dior = ide_dior_n;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ide_dd_in = lfsr;
    wr_data   = lfsr ^ 16'h5A3C;
    wr_valid  = wv_mode ? (lfsr[0] | lfsr[4]) : 1'b1;
    rd_ready  = rr_mode ? (lfsr[2] | lfsr[7]) : 1'b1;
    ide_dmarq = dq_mode ? (lfsr[1] | lfsr[9]) : dq_level;
    stb_cnt++;
    if (stb_per != 0 && stb_cnt >= stb_per) begin
      stb_cnt = 0;
      ide_dstrobe = !ide_dstrobe;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int k = 0;
    while (ph != 0 && k < 3000) begin @(negedge clk); k++; end
    if (k >= 3000) begin
      miscompares++;
      $display("FAIL watchdog: transfer did not finish, got busy expected idle");
    end
    @(negedge clk);
  endtask

  task automatic start(int m, bit w, int n, int a, int r);
    seen_done = 0; seen_err = 0; rdv_count = 0; tog_count = 0;
    @(negedge clk);
    req_mode = 2'(m); req_write = w; req_count = 16'(n);
    cfg_active = 6'(a); cfg_recover = 6'(r); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: global limit, got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(3);
    chk("R1", "dior_n in reset", ide_dior_n, 1);
    chk("R1", "diow_n in reset", ide_diow_n, 1);
    chk("R1", "dmack_n in reset", ide_dmack_n, 1);
    chk("R1", "diow_oe in reset", ide_diow_oe, 1);
    rst = 1'b0;
    cyc(2);
    chk("R1", "done after reset", done, 0);

    // R2 R3: PIO read, three words
    start(0, 0, 3, 2, 1); wait_idle();
    chk("R3", "PIO read words", rdv_count, 3);
    chk("R2", "PIO read done", seen_done, 1);

    // R4: PIO write with gaps on the write stream
    wv_mode = 1;
    start(0, 1, 2, 3, 2); wait_idle();
    chk("R4", "PIO write done", seen_done, 1);
    wv_mode = 0;

    // R2: zero timing fields act as one
    rr_mode = 1;
    start(3, 0, 2, 0, 0); wait_idle();
    chk("R2", "min timing read words", rdv_count, 2);
    rr_mode = 0;

    // R5: multiword DMA read waits for the request
    dq_level = 0;
    start(1, 0, 3, 2, 2); cyc(4);
    chk("R5", "dmack_n before request", ide_dmack_n, 1);
    chk("R5", "dior_n before request", ide_dior_n, 1);
    dq_mode = 1; wait_idle();
    chk("R5", "MDMA read words", rdv_count, 3);
    chk("R5", "dmack_n after done", ide_dmack_n, 1);

    // R5 R4: multiword DMA write with a bursty request
    start(1, 1, 2, 1, 3); wait_idle();
    chk("R5", "MDMA write done", seen_done, 1);
    dq_mode = 0; dq_level = 1;

    // R7 R8: Ultra DMA write runs to its count
    wv_mode = 1;
    start(2, 1, 4, 1, 1); wait_idle();
    chk("R7", "UDMA write strobe toggles", tog_count, 4);
    chk("R8", "UDMA write done", seen_done, 1);
    chk("R9", "UDMA write no error", seen_err, 0);
    wv_mode = 0;

    // R9: device drops its request mid burst
    start(2, 1, 6, 1, 1); cyc(6);
    dq_level = 0; wait_idle();
    chk("R9", "UDMA write early stop error", seen_err, 1);
    chk("R8", "UDMA write early stop done", seen_done, 1);
    dq_level = 1;

    // R6: Ultra DMA read with host pauses
    rr_mode = 1; stb_per = 3;
    start(2, 0, 3, 1, 1); wait_idle();
    chk("R6", "UDMA read words", rdv_count, 3);
    chk("R9", "UDMA read no error", seen_err, 0);
    rr_mode = 0;

    // R9: Ultra DMA read stopped by the device
    stb_per = 4;
    start(2, 0, 5, 1, 1); cyc(8);
    dq_level = 0; wait_idle();
    chk("R9", "UDMA read early stop error", seen_err, 1);
    stb_per = 0; dq_level = 1;

    // R10: empty request
    start(0, 0, 0, 2, 2); wait_idle();
    chk("R10", "zero count done", seen_done, 1);
    chk("R10", "zero count no error", seen_err, 0);

    // R11: suspend abandons a long PIO write
    start(0, 1, 3, 20, 2); cyc(5);
    suspend = 1'b1; cyc(2);
    chk("R11", "diow_oe in suspend", ide_diow_oe, 0);
    chk("R11", "dior_n in suspend", ide_dior_n, 1);
    chk("R11", "dmack_n in suspend", ide_dmack_n, 1);
    chk("R11", "req_ready in suspend", req_ready, 0);
    chk("R11", "no done on abandon", seen_done, 0);
    suspend = 1'b0; cyc(2);
    chk("R11", "diow_oe after suspend", ide_diow_oe, 1);

    // R4: channel works again after suspend
    start(0, 1, 1, 2, 1); wait_idle();
    chk("R4", "write after suspend done", seen_done, 1);

    cyc(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule